// File: doc/BRIEF.md
# Modulo 2^N+1 Parallel-Prefix Adder

This block adds two residues modulo 2^N+1 held in plain weighted binary. Each operand is N+1 bits wide and lies in the range 0 to 2^N. The result is the residue of their sum, in the same form. It is intended for the odd channel of a residue-number datapath, where it must keep pace with the 2^N and 2^N-1 channels.

The arithmetic runs in three steps:
- A carry-save row folds the constant 2^N-1 into the two operands, giving a sum vector and a carry vector.
- One Kogge-Stone carry tree of ceil(log2 N) levels resolves every group carry.
- A fix-up row injects the end-around correction, and an XOR row forms the sum bits.

The top result bit does not come from the carries. It has its own operand, an "exact half-sum" lane that travels through the same tree alongside generate and propagate. This lane is set only when the sum equals exactly 2^N.

A generate switch selects one of two variants: a purely combinational result, or one that is registered on the rising clock edge with an asynchronous active-low clear.

Top module: `modp1_adder`

## Requirements
- R1: For any two operands in 0..2^N the result `r` never exceeds 2^N.
- R2: For any two operands in 0..2^N, `r` equals (a + b) mod (2^N + 1).
- R3: Bit N of `r` is 1 exactly when a + b = 2^N, and whenever bit N is 1 bits N-1..0 are all 0.
- R4: With N = 4, a = 12 and b = 12 give r = 7, with bit 4 of `r` equal to 0.
- R5: With both operands equal to 2^N the result is 2^N - 1 (15 for N = 4, 255 for N = 8).
- R6: With OUT_REG = 1, a new result appears on `r` at the first rising edge of `clk` after the operands change, and `r` keeps its previous value until that edge.
- R7: With OUT_REG = 0, `r` follows the operands with no clock edge in between.
- R8: With OUT_REG = 1, `r` is 0 while `rst_n` is low, independent of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| a | input | N+1 | First operand, 0..2^N |
| b | input | N+1 | Second operand, 0..2^N |
| r | output | N+1 | Residue (a + b) mod (2^N + 1) |

## Verification
The bench builds four copies of the adder:
- N = 2, combinational;
- N = 4, registered;
- N = 7, registered;
- N = 8, combinational.

Each copy is swept over every legal operand pair. The sweeps cover every case where the end-around correction fires and every case where the sum lands exactly on 2^N. Together they exercise trees of one, two and three prefix levels, including the uneven last level at N = 7.

The N = 4 copy also carries the directed cases: the 12 + 12 case, the 2^N + 2^N extreme, the timing of the output register, and the asynchronous clear.

// File: rtl/modp1_pkg.sv
package modp1_pkg;

   // One prefix cell: carry generate, carry propagate (inclusive),
   // and the exact half-sum lane (exclusive propagate) used for the top bit.
   typedef struct packed {
      logic g;
      logic p;
      logic t;
   } gpt_t;

   // hi covers the more significant span, lo the less significant one.
   function automatic gpt_t gpt_join(input gpt_t hi, input gpt_t lo);
      gpt_t res;
      res.g = hi.g | (hi.p & lo.g);
      res.p = hi.p & lo.p;
      res.t = hi.t & lo.t;
      return res;
   endfunction

endpackage

// File: rtl/modp1_csa.sv
// Carry-save row adding the constant 2^N-1 to a + b.
module modp1_csa #(
   parameter int unsigned N = 8
) (
   input  logic [N:0] a,
   input  logic [N:0] b,
   output logic [N:0] s,
   output logic [N:0] c
);
   for (genvar i = 0; i <= N; i++) begin : g_col
      if (i < N) begin : g_low
         // a_i + b_i + 1 split into sum and carry
         assign s[i] = ~(a[i] ^ b[i]);
         assign c[i] = a[i] | b[i];
      end else begin : g_top
         assign s[i] = a[i] ^ b[i];
         assign c[i] = a[i] & b[i];
      end
   end
endmodule

// File: rtl/modp1_prefix_tree.sv
// Kogge-Stone prefix tree; leaf k stands for bit position k+1.
module modp1_prefix_tree
   import modp1_pkg::*;
#(
   parameter int unsigned N = 8
) (
   input  gpt_t leaf [N],
   output gpt_t grp  [N]
);
   localparam int unsigned LVL = (N > 1) ? $clog2(N) : 1;

   gpt_t stage [LVL+1][N];

   for (genvar k = 0; k < N; k++) begin : g_in
      assign stage[0][k] = leaf[k];
   end

   for (genvar l = 0; l < LVL; l++) begin : g_lvl
      localparam int unsigned SPAN = 1 << l;
      for (genvar k = 0; k < N; k++) begin : g_cell
         if (k >= SPAN) begin : g_join
            assign stage[l+1][k] = gpt_join(stage[l][k], stage[l][k-SPAN]);
         end else begin : g_pass
            assign stage[l+1][k] = stage[l][k];
         end
      end
   end

   for (genvar k = 0; k < N; k++) begin : g_out
      assign grp[k] = stage[LVL][k];
   end
endmodule

// File: rtl/modp1_finish.sv
// End-around fix-up row and sum formation.
module modp1_finish
   import modp1_pkg::*;
#(
   parameter int unsigned N = 8
) (
   input  logic [N:0] s,
   input  logic [N:0] c,
   input  gpt_t       grp [N],
   output logic [N:0] sum
);
   logic [N-1:0] g_v, p_v, t_v;
   logic         no_wrap;   // sum of s and 2c stayed below 2^(N+1)
   logic         k0;        // carry out of bit 0 after the correction
   logic [N-1:0] cin;       // carry into bit i, index 0 unused

   for (genvar k = 0; k < N; k++) begin : g_split
      assign g_v[k] = grp[k].g;
      assign p_v[k] = grp[k].p;
      assign t_v[k] = grp[k].t;
   end

   assign no_wrap = ~c[N] & ~g_v[N-1];
   assign k0      = s[0] & no_wrap;
   assign cin[0]  = 1'b0;
   assign sum[0]  = s[0] ^ no_wrap;

   for (genvar i = 1; i < N; i++) begin : g_bit
      if (i == 1) begin : g_first
         assign cin[i] = k0;
      end else begin : g_rest
         assign cin[i] = g_v[i-2] | (p_v[i-2] & k0);
      end
      assign sum[i] = s[i] ^ c[i-1] ^ cin[i];
   end

   // Top bit: every column from 1 to N holds exactly one bit, bit 0 of the sum
   // vector is set, and nothing leaves column N.
   assign sum[N] = s[0] & ~c[N] & t_v[N-1];

   logic unused_cells;
   assign unused_cells = ^{g_v[N-2], p_v[N-1:N-2], t_v[N-2:0], cin[0]};
endmodule

// File: rtl/modp1_adder.sv
module modp1_adder
   import modp1_pkg::*;
#(
   parameter int unsigned N       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [N:0] a,
   input  logic [N:0] b,
   output logic [N:0] r
);
   if (N < 2 || N > 16) begin : g_bad_n
      $error("modp1_adder: N must lie in 2..16");
   end

   logic [N:0] s, c, sum;
   gpt_t       leaf [N];
   gpt_t       grp  [N];

   modp1_csa #(.N(N)) u_csa (
      .a(a), .b(b), .s(s), .c(c)
   );

   for (genvar k = 0; k < N; k++) begin : g_leaf
      assign leaf[k].g = s[k+1] & c[k];
      assign leaf[k].p = s[k+1] | c[k];
      assign leaf[k].t = s[k+1] ^ c[k];
   end

   modp1_prefix_tree #(.N(N)) u_tree (
      .leaf(leaf), .grp(grp)
   );

   modp1_finish #(.N(N)) u_fin (
      .s(s), .c(c), .grp(grp), .sum(sum)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= '0;
         else        r <= sum;
      end
   end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n;
      assign r = sum;
   end
endmodule

// File: rtl/modp1_adder_chk.sv
module modp1_adder_chk #(
   parameter int unsigned N       = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [N:0] a,
   input logic [N:0] b,
   input logic [N:0] r
);
   localparam logic [N+1:0] MODV = (N+2)'((1 << N) + 1);
   localparam logic [N:0]   LIM  = (N+1)'(1) << N;

   function automatic logic [N:0] spec_mod(input logic [N:0] x, input logic [N:0] y);
      logic [N+1:0] t;
      t = {1'b0, x} + {1'b0, y};
      if (t >= MODV) t = t - MODV;
      return t[N:0];
   endfunction

   logic legal_now;
   assign legal_now = (a <= LIM) && (b <= LIM);

   // R3: a set top bit comes with all lower bits clear
   a_r3_msb_alone: assert property (@(posedge clk) disable iff (!rst_n)
      r[N] |-> (r[N-1:0] == '0));

   if (OUT_REG) begin : g_reg
      logic       seen, legal_q;
      logic [N:0] exp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen    <= 1'b0;
            legal_q <= 1'b0;
            exp_q   <= '0;
         end else begin
            seen    <= 1'b1;
            legal_q <= legal_now;
            exp_q   <= spec_mod(a, b);
         end
      end

      a_r2_value: assert property (@(posedge clk) disable iff (!rst_n)
         (seen && legal_q) |-> (r == exp_q));
      a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
         (seen && legal_q) |-> (r <= LIM));
      a_r3_msb_exact: assert property (@(posedge clk) disable iff (!rst_n)
         (seen && legal_q && exp_q == LIM) |-> r[N]);
      a_r8_clear: assert property (@(posedge clk)
         !rst_n |-> (r == '0));
   end else begin : g_comb
      a_r2_value: assert property (@(posedge clk) disable iff (!rst_n)
         legal_now |-> (r == spec_mod(a, b)));
      a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
         legal_now |-> (r <= LIM));
      a_r3_msb_exact: assert property (@(posedge clk) disable iff (!rst_n)
         (legal_now && ({1'b0, a} + {1'b0, b}) == {1'b0, LIM}) |-> r[N]);
   end
endmodule

bind modp1_adder modp1_adder_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .a(a), .b(b), .r(r)
);

// File: tb/modp1_adder_test.sv
`timescale 1ns/1ps
module modp1_adder_test;
   logic clk = 1'b0;
   logic rst_n = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   logic [2:0] a2 = '0, b2 = '0; logic [2:0] r2;
   logic [4:0] a4 = '0, b4 = '0; logic [4:0] r4;
   logic [7:0] a7 = '0, b7 = '0; logic [7:0] r7;
   logic [8:0] a8 = '0, b8 = '0; logic [8:0] r8;

   modp1_adder #(.N(4), .OUT_REG(1'b1)) uut    (.clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .r(r4));
   modp1_adder #(.N(2), .OUT_REG(1'b0)) uut_n2 (.clk(clk), .rst_n(rst_n), .a(a2), .b(b2), .r(r2));
   modp1_adder #(.N(7), .OUT_REG(1'b1)) uut_n7 (.clk(clk), .rst_n(rst_n), .a(a7), .b(b7), .r(r7));
   modp1_adder #(.N(8), .OUT_REG(1'b0)) uut_n8 (.clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .r(r8));

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic drive(input int n, input int x, input int y);
      case (n)
         2: begin a2 = 3'(x); b2 = 3'(y); end
         4: begin a4 = 5'(x); b4 = 5'(y); end
         7: begin a7 = 8'(x); b7 = 8'(y); end
         default: begin a8 = 9'(x); b8 = 9'(y); end
      endcase
   endtask

   function automatic int rd(input int n);
      case (n)
         2: return int'(r2);
         4: return int'(r4);
         7: return int'(r7);
         default: return int'(r8);
      endcase
   endfunction

   task automatic check_pair(input int n, input int x, input int y);
      int lim = 1 << n;
      int exp = (x + y) % (lim + 1);
      int act = rd(n);
      chk(act == exp, $sformatf("R2 n=%0d a=%0d b=%0d", n, x, y), act, exp);
      chk(act <= lim, $sformatf("R1 n=%0d a=%0d b=%0d", n, x, y), act, lim);
      chk(((act >> n) & 1) == int'(x + y == lim),
          $sformatf("R3 n=%0d a=%0d b=%0d", n, x, y), (act >> n) & 1, int'(x + y == lim));
   endtask

   // Drive one pair per falling edge; check the previous pair first.
   task automatic sweep(input int n);
      int lim = 1 << n;
      int pa = 0, pb = 0;
      bit pend = 1'b0;
      for (int x = 0; x <= lim; x++) begin
         for (int y = 0; y <= lim; y++) begin
            @(negedge clk);
            if (pend) check_pair(n, pa, pb);
            drive(n, x, y);
            pa = x; pb = y; pend = 1'b1;
         end
      end
      @(negedge clk);
      check_pair(n, pa, pb);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      #1 rst_n = 1'b0;
      #1 chk(r4 == 5'd0, "R8 reset state n=4", int'(r4), 0);
      chk(r7 == 8'd0, "R8 reset state n=7", int'(r7), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R4: 12 + 12 mod 17
      @(negedge clk); drive(4, 12, 12);
      @(negedge clk);
      chk(r4 == 5'd7, "R4 12+12 value", int'(r4), 7);
      chk(r4[4] == 1'b0, "R4 12+12 top bit", int'(r4[4]), 0);

      // R5: both operands at the top of the range
      drive(4, 16, 16); drive(8, 256, 256);
      #1 chk(r8 == 9'd255, "R5 n=8 256+256", int'(r8), 255);
      @(negedge clk);
      chk(r4 == 5'd15, "R5 n=4 16+16", int'(r4), 15);

      // R6: registered output holds until the next rising edge
      drive(4, 3, 5);
      #1 chk(r4 == 5'd15, "R6 hold before edge", int'(r4), 15);
      @(negedge clk);
      chk(r4 == 5'd8, "R6 update after edge", int'(r4), 8);

      // R7: combinational copy responds with no clock edge
      drive(2, 4, 4);
      #1 chk(r2 == 3'd3, "R7 n=2 4+4 without edge", int'(r2), 3);

      // R8: asynchronous clear in mid-run
      @(negedge clk); rst_n = 1'b0;
      #1 chk(r4 == 5'd0, "R8 clear n=4", int'(r4), 0);
      chk(r7 == 8'd0, "R8 clear n=7", int'(r7), 0);
      @(negedge clk); rst_n = 1'b1;
      drive(2, 0, 0); drive(4, 0, 0); drive(8, 0, 0);

      // R1 R2 R3: exhaustive sweeps
      sweep(2);
      sweep(4);
      sweep(7);
      sweep(8);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule